// File: doc/BRIEF.md
# Prescaled Watchdog with Pulsed Timeout Outputs

This block watches over software by counting down from a programmed start value. If software does not restart it before the count runs out, it drives a set of timeout outputs for a programmed number of prescaled clock periods. It then holds a sticky flag and stays stopped until software acts again. The input clock is first divided by a selectable prescaler, and each decrement of the counter happens on one prescaled tick. The count field that software writes is widened into a much larger start value by appending a run of one bits below it.

Software reaches the block through a plain write port with a 2-bit address. Address 0 holds the mode: enable, per-output enables and pulse width, guarded by a key. Address 1 holds the prescale select and the count field. Address 2 takes the restart command, which needs its own key. Address 3 clears the sticky flag. The timeout outputs go to whatever the system wires them to, such as a reset request, an interrupt line or an external pin.

Top module: `wdog_pulse`

## Requirements
- R1: The prescaler divides the clock by 2^(PRE_STEP*(s+1)), where s is timing register bits [1:0]. With the default PRE_STEP=3 the divides are 8, 64, 512 and 4096.
- R2: A load sets the counter to the count field (timing bits [CNT_W+1:2]) with LOW_BITS one bits appended below it. The timeout outputs rise (start+1) prescaled ticks after the load, which is (start+1)*divide clock cycles after the loading write.
- R3: During a pulse, wdt_out equals the output-enable field (mode bits [N_OUT:1]). Disabled outputs stay low.
- R4: Mode bits [9:8] select a pulse width of 4, 8, 16 or 32 prescaled ticks. The outputs stay high for exactly width*divide clock cycles.
- R5: A write to address 2 whose low 16 bits equal 16'h1999 reloads the counter and clears the prescaler. Any other value has no effect.
- R6: A write to address 0 takes effect only if bits [31:20] equal 12'hABC. Otherwise the write is discarded. Mode bit 0 is the enable, and a 0-to-1 change of it loads the counter.
- R7: tmo_flag sets when a timeout starts. It clears only when address 3 is written with bit 0 set, and writing 0 there leaves it set.
- R8: After a pulse ends, the outputs stay low and the counter stays stopped. Only a keyed restart, or a disable followed by an enable, starts it again.
- R9: A valid mode write with enable 0 stops the counter and forces wdt_out low from the next cycle.
- R10: A keyed restart that arrives during a pulse is ignored, and the pulse runs to its full width.
- R11: After reset, wdt_out and tmo_flag are 0 and the watchdog is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 timing, 2 restart, 3 status clear |
| wr_data | input | 32 | Write data |
| wdt_out | output | N_OUT | Timeout outputs, high during a pulse where enabled |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with PRE_STEP=1, LOW_BITS=2 and CNT_W=4. These values shrink the prescale divides to 2, 4, 8 and 16 and make start values of 3 to 63 ticks, so every prescale select and every pulse width can be timed to the exact cycle in a short run. Because the same formulas apply at these sizes, the timing checks of the load delay and the pulse length hold for the default sizes as well. Key rejection, the restart that arrives during a pulse and the halt after a pulse are each timed against the expected edge.

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int N_OUT    = 3,
  parameter int CNT_W    = 12,
  parameter int LOW_BITS = 12,
  parameter int PRE_STEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic [N_OUT-1:0] wdt_out,
  output logic             tmo_flag
);
  localparam int CW    = CNT_W + LOW_BITS;
  localparam int PRE_W = 4 * PRE_STEP;
  localparam logic [11:0] MODE_KEY  = 12'hABC;
  localparam logic [15:0] START_KEY = 16'h1999;

  typedef enum logic [1:0] {S_OFF, S_RUN, S_PULSE, S_HALT} st_t;
  st_t st;

  logic             en_r;
  logic [N_OUT-1:0] oen_r;
  logic [1:0]       wsel_r, psel_r;
  logic [CNT_W-1:0] cfld_r;
  logic [CW-1:0]    cnt;
  logic [PRE_W-1:0] pre;
  logic [5:0]       pw;
  logic             unused_bits;

  assign unused_bits = ^wr_data;

  wire mode_wr = wr_en && wr_addr == 2'd0 && wr_data[31:20] == MODE_KEY;
  wire time_wr = wr_en && wr_addr == 2'd1;
  wire kick_ok = wr_en && wr_addr == 2'd2 && wr_data[15:0] == START_KEY;
  wire clr_wr  = wr_en && wr_addr == 2'd3 && wr_data[0];
  wire stop_wr = mode_wr && !wr_data[0];
  wire en_rise = mode_wr && wr_data[0] && !en_r;
  wire reload  = en_rise || (kick_ok && en_r && st != S_PULSE);

  wire [PRE_W-1:0] div_last = {PRE_W{1'b1}} >> (PRE_STEP * (3 - int'(psel_r)));
  wire counting = (st == S_RUN) || (st == S_PULSE);
  wire tick     = counting && pre == div_last;
  wire [CW-1:0] start_val = {cfld_r, {LOW_BITS{1'b1}}};
  wire [5:0] pw_load = (6'd4 << wsel_r) - 6'd1;

  assign wdt_out = (st == S_PULSE) ? oen_r : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= 1'b0;
      oen_r  <= '0;
      wsel_r <= '0;
      psel_r <= '0;
      cfld_r <= '0;
    end else begin
      if (mode_wr) begin
        en_r   <= wr_data[0];
        oen_r  <= wr_data[N_OUT:1];
        wsel_r <= wr_data[9:8];
      end
      if (time_wr) begin
        psel_r <= wr_data[1:0];
        cfld_r <= wr_data[CNT_W+1:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
      pre <= '0;
      pw  <= '0;
    end else if (stop_wr) begin
      st  <= S_OFF;
      pre <= '0;
    end else if (reload) begin
      st  <= S_RUN;
      cnt <= start_val;
      pre <= '0;
    end else begin
      if (counting) pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        if (st == S_RUN) begin
          if (cnt == '0) begin
            st <= S_PULSE;
            pw <= pw_load;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else if (pw == '0) begin
          st <= S_HALT;
        end else begin
          pw <= pw - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                tmo_flag <= 1'b0;
    else if (tick && st == S_RUN && cnt == '0) tmo_flag <= 1'b1;
    else if (clr_wr)                           tmo_flag <= 1'b0;
  end

  assert_pulse_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_PULSE) |-> $past(cnt) == '0);

  assert_flag_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|wdt_out) |-> tmo_flag);

  assert_bad_kick_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && !kick_ok && !mode_wr && st == S_RUN && !tick) |=> $stable(cnt));

  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT && !kick_ok && !mode_wr) |=> (st == S_HALT && wdt_out == '0));

  assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> wdt_out == '0);

  assert_kick_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE && kick_ok && !mode_wr && !tick) |=> (st == S_PULSE && $stable(pw)));
endmodule

// File: tb/wdog_pulse_tb.sv
module wdog_pulse_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wdt_out;
  logic        tmo_flag;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_pulse #(.N_OUT(3), .CNT_W(4), .LOW_BITS(2), .PRE_STEP(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdt_out(wdt_out), .tmo_flag(tmo_flag));

  // cnt, psel, wsel, oen, expected delay, expected high cycles
  localparam int VEC [5][6] = '{
    '{ 0, 0, 0, 1,    8,   8},
    '{ 1, 1, 1, 2,   32,  32},
    '{ 2, 2, 0, 5,   96,  32},
    '{ 3, 0, 3, 7,   32,  64},
    '{15, 3, 2, 6, 1024, 256}
  };

  function automatic logic [31:0] mword(input logic [11:0] key, input logic [1:0] ws,
                                        input logic [2:0] oe, input logic en);
    return {key, 10'b0, ws, 4'b0, oe, en};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_high(output int k);
    k = 0;
    while (wdt_out == 0 && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic measure_high(output int h);
    h = 0;
    while (wdt_out != 0 && h < 3000) begin h++; @(negedge clk); end
  endtask

  task automatic setup(input int c, input int ps, input int ws, input int oe);
    wr(2'd0, mword(12'hABC, 2'd0, 3'd0, 1'b0));
    wr(2'd1, 32'((c << 2) | ps));
    wr(2'd3, 32'd1);
    wr(2'd0, mword(12'hABC, 2'(ws), 3'(oe), 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int k, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wdt_out == 0, "R11 out", int'(wdt_out), 0);
    chk(tmo_flag == 0, "R11 flag", int'(tmo_flag), 0);
    repeat (50) @(negedge clk);
    chk(wdt_out == 0, "R11 idle", int'(wdt_out), 0);

    foreach (VEC[i]) begin
      setup(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      wait_high(k);
      chk(k == VEC[i][4], "R1 R2 delay", k, VEC[i][4]);
      chk(int'(wdt_out) == VEC[i][3], "R3 enables", int'(wdt_out), VEC[i][3]);
      chk(tmo_flag == 1, "R7 set", int'(tmo_flag), 1);
      measure_high(h);
      chk(h == VEC[i][5], "R4 width", h, VEC[i][5]);
      repeat (40) @(negedge clk);
      chk(wdt_out == 0, "R8 halted", int'(wdt_out), 0);
    end

    // sticky flag
    wr(2'd3, 32'd0);
    chk(tmo_flag == 1, "R7 write0", int'(tmo_flag), 1);
    wr(2'd3, 32'd1);
    chk(tmo_flag == 0, "R7 clear", int'(tmo_flag), 0);

    // restart with good and bad key (start 3, divide 2 -> 8 cycles)
    setup(0, 0, 0, 1);
    repeat (5) @(negedge clk);
    wr(2'd2, 32'h1999);
    wait_high(k);
    chk(k == 8, "R5 good key reload", k, 8);
    measure_high(h);
    setup(0, 0, 0, 1);
    repeat (5) @(negedge clk);
    wr(2'd2, 32'h1998);
    wait_high(k);
    chk(k == 2, "R5 bad key ignored", k, 2);
    measure_high(h);

    // halt then keyed restart
    repeat (30) @(negedge clk);
    chk(wdt_out == 0, "R8 stopped", int'(wdt_out), 0);
    wr(2'd2, 32'h1999);
    wait_high(k);
    chk(k == 8, "R8 restart resumes", k, 8);

    // restart during pulse ignored
    @(negedge clk); @(negedge clk);
    wr(2'd2, 32'h1999);
    measure_high(h);
    chk(h == 5, "R10 kick in pulse", h, 5);

    // re-enable from halt
    wr(2'd0, mword(12'hABC, 2'd0, 3'd1, 1'b0));
    wr(2'd0, mword(12'hABC, 2'd0, 3'd1, 1'b1));
    wait_high(k);
    chk(k == 8, "R8 re-enable", k, 8);

    // disable during pulse
    wr(2'd0, mword(12'hABC, 2'd0, 3'd1, 1'b0));
    chk(wdt_out == 0, "R9 pulse cut", int'(wdt_out), 0);
    repeat (60) @(negedge clk);
    chk(wdt_out == 0, "R9 stays off", int'(wdt_out), 0);

    // disable while running
    setup(0, 0, 0, 1);
    repeat (3) @(negedge clk);
    wr(2'd0, mword(12'hABC, 2'd0, 3'd1, 1'b0));
    repeat (40) @(negedge clk);
    chk(wdt_out == 0, "R9 run stop", int'(wdt_out), 0);

    // bad mode key: enable rejected
    wr(2'd3, 32'd1);
    wr(2'd0, mword(12'hABD, 2'd0, 3'd7, 1'b1));
    repeat (40) @(negedge clk);
    chk(wdt_out == 0, "R6 bad enable", int'(wdt_out), 0);
    chk(tmo_flag == 0, "R6 no timeout", int'(tmo_flag), 0);

    // bad mode key: disable rejected while running
    setup(0, 0, 0, 1);
    repeat (2) @(negedge clk);
    wr(2'd0, mword(12'h123, 2'd0, 3'd0, 1'b0));
    wait_high(k);
    chk(k == 5, "R6 bad disable", k, 5);
    chk(wdt_out == 3'd1, "R6 enables kept", int'(wdt_out), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule